// File: doc/BRIEF.md
# Strap-Configured Index/Data Register Port with ID Unlock

This block gives a host processor access to a small bank of configuration registers over a 10-bit I/O address space. It answers at four byte ports. An ID-in port takes ID codes. An index port selects a register. A data port reads and writes the selected register. An ID-out port reports the chip ID. Which base address the ports sit at is fixed by a strap that is captured while reset is held.

A second strap picks the operating mode. In single-chip mode the index and data ports are always open. In multi-chip mode several such blocks can share one bus. Each block keeps its ports closed until the host writes its chip ID to the ID-in port. That chip ID is a 2-bit value taken from two more straps. Writing any other code closes the ports again. Reads go through a combinational mux, so `io_rdata` is valid in the same cycle as `io_rd`. Writes take effect at the clock edge.

The register bank covers indices 80h to 8Fh. Four of these indices are read-only constants. The other twelve are read/write and have fixed reset defaults.

Top module: `cfgport_top`

## Requirements
- R1: While reset is held, `strap_base` is captured. When it is 1, the ID-in, index, data and ID-out ports sit at 1B0h, 1B4h, 1B8h and 1BCh. When it is 0, they sit at 130h, 134h, 138h and 13Ch. The index, data and ID-out ports need all 10 address bits to match.
- R2: The ID-in port is also decoded at alias addresses. Address bit 8 is ignored for it, and bit 9 must be 0. So with the high base it answers at 0B0h and 1B0h but not at 2B0h or 3B0h.
- R3: When the captured `strap_single` is 1, the index and data ports are always open.
- R4: When `strap_single` is 0, a write to the ID-in port of the value {6'b0, chip ID} opens the ports from the next cycle. A write of any other value closes them.
- R5: The chip ID is {`strap_id1`,`strap_id0`}, captured during reset. While the ports are open, a read of the ID-out port returns {6'b0, chip ID}. While they are closed, it returns FFh.
- R6: While the ports are closed, writes to the index and data ports are ignored, and reads of the index and data ports return FFh.
- R7: The index register is 8 bits wide and resets to 00h. It is written through the index port and reads back through it.
- R8: After reset, the read/write registers hold these values: 81h = 8Fh, 83h = FFh, 85h = FFh, 86h = 80h, and 88h to 8Fh = 00h.
- R9: Indices 80h, 82h, 84h and 87h are read-only. They read 8Fh, FFh, FFh and 8Ah (the revision), and writes to them are dropped.
- R10: When the index is outside 80h to 8Fh, the data port reads FFh and data writes are dropped, without touching any in-range register.
- R11: `io_rdata` is FFh when `io_rd` is low, when the address hits no port, and when the write-only ID-in port is read.
- R12: The straps are only sampled while `rst_n` is low. Changes after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| strap_base | input | 1 | Base select strap: 1 selects 1Bxh, 0 selects 13xh |
| strap_single | input | 1 | Mode strap: 1 for single-chip, 0 for multi-chip |
| strap_id1 | input | 1 | Chip ID bit 1 strap |
| strap_id0 | input | 1 | Chip ID bit 0 strap |
| io_addr | input | 10 | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |

## Verification
The assertions check the following on every cycle:
- at most one port decodes;
- `io_rdata` is FFh when no read is in progress;
- closed ports read FFh and do not change the index;
- the unlock state follows each ID-in write according to the written value;
- the ID-out and revision reads return their values;
- the captured straps stay frozen after reset.

Some behaviour only the bench's sweeps can show:
- that each address alias opens or misses as expected;
- that all 256 index values produce the right data-port result;
- that writes to out-of-range or read-only indices leave every stored register unchanged;
- that the same rules hold under every strap combination.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 8;
  localparam int ID_W    = 2;
  localparam int NREG    = 16;
  localparam int OFS_W   = $clog2(NREG);
  localparam logic [DATA_W-1:0] IDX_BASE = 8'h80;
  localparam logic [DATA_W-1:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    PORT_IDIN  = 2'd0,
    PORT_INDEX = 2'd1,
    PORT_DATA  = 2'd2,
    PORT_IDOUT = 2'd3
  } port_e;

  // Address of one port for a given base strap value.
  function automatic logic [ADDR_W-1:0] port_addr(input logic base_hi, input port_e p);
    logic [ADDR_W-1:0] base;
    base = base_hi ? 10'h1B0 : 10'h130;
    return base + {6'b0, p, 2'b00};
  endfunction

  // ID-in alias match: bit 9 zero, bit 8 don't care, low byte exact.
  function automatic logic idin_match(input logic [ADDR_W-1:0] a, input logic base_hi);
    logic [ADDR_W-1:0] ref_a;
    ref_a = port_addr(base_hi, PORT_IDIN);
    return (a[9] == 1'b0) && (a[7:0] == ref_a[7:0]);
  endfunction

  function automatic logic reg_is_ro(input int i);
    return (i == 0) || (i == 2) || (i == 4) || (i == 7);
  endfunction

  function automatic logic [DATA_W-1:0] reg_default(input int i, input logic [DATA_W-1:0] rev);
    case (i)
      0, 1:       return 8'h8F;
      2, 3, 4, 5: return 8'hFF;
      6:          return 8'h80;
      7:          return rev;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] id_byte(input logic [ID_W-1:0] id);
    return {{(DATA_W-ID_W){1'b0}}, id};
  endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              base_hi,
  output logic              hit_idin,
  output logic              hit_index,
  output logic              hit_data,
  output logic              hit_idout
);

  assign hit_idin  = idin_match(addr, base_hi);
  assign hit_index = (addr == port_addr(base_hi, PORT_INDEX));
  assign hit_data  = (addr == port_addr(base_hi, PORT_DATA));
  assign hit_idout = (addr == port_addr(base_hi, PORT_IDOUT));

endmodule

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_mode,
  input  logic [ID_W-1:0]   chip_id,
  input  logic              idin_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              seq_active,
  output logic              access_open
);

  typedef enum logic {ST_LOCKED = 1'b0, ST_OPEN = 1'b1} ulk_e;
  ulk_e state_q;

  logic id_hit;
  assign id_hit = (wdata == id_byte(chip_id));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LOCKED;
    end else if (idin_wr && !single_mode) begin
      state_q <= id_hit ? ST_OPEN : ST_LOCKED;
    end
  end

  assign seq_active  = (state_q == ST_OPEN);
  assign access_open = single_mode | seq_active;

endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
  import cfgport_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_ID = 8'h8A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] index,
  input  logic [DATA_W-1:0] wdata,
  output logic              in_range,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ofs_full;
  logic [OFS_W-1:0]  ofs;
  logic [DATA_W-1:0] q [NREG];

  assign ofs_full = index - IDX_BASE;
  assign in_range = (index >= IDX_BASE) && ({1'b0, index} < ({1'b0, IDX_BASE} + 9'(NREG)));
  assign ofs      = ofs_full[OFS_W-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (reg_is_ro(g)) begin : g_ro
      assign q[g] = reg_default(g, REV_ID);
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q[g] <= reg_default(g, REV_ID);
        end else if (wr_en && in_range && (ofs == OFS_W'(g))) begin
          q[g] <= wdata;
        end
      end
    end
  end

  assign rdata = in_range ? q[ofs] : IDLE_BYTE;

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h8A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_base,
  input  logic        strap_single,
  input  logic        strap_id1,
  input  logic        strap_id0,
  input  logic [9:0]  io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata
);

  logic            base_q;
  logic            single_q;
  logic [ID_W-1:0] chip_id_q;
  logic [DATA_W-1:0] index_q;

  logic hit_idin, hit_index, hit_data, hit_idout;
  logic seq_active, access_open;
  logic idin_wr, index_wr, data_wr;
  logic reg_in_range;
  logic [DATA_W-1:0] reg_rdata;

  // Straps captured only while reset is asserted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= strap_base;
      single_q  <= strap_single;
      chip_id_q <= {strap_id1, strap_id0};
    end
  end

  cfgport_decode u_dec (
    .addr      (io_addr),
    .base_hi   (base_q),
    .hit_idin  (hit_idin),
    .hit_index (hit_index),
    .hit_data  (hit_data),
    .hit_idout (hit_idout)
  );

  assign idin_wr  = io_wr & hit_idin;
  assign index_wr = io_wr & hit_index & access_open;
  assign data_wr  = io_wr & hit_data & access_open;

  cfgport_unlock u_ulk (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_mode (single_q),
    .chip_id     (chip_id_q),
    .idin_wr     (idin_wr),
    .wdata       (io_wdata),
    .seq_active  (seq_active),
    .access_open (access_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
    end else if (index_wr) begin
      index_q <= io_wdata;
    end
  end

  cfgport_regfile #(.REV_ID(REV_ID)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (data_wr),
    .index    (index_q),
    .wdata    (io_wdata),
    .in_range (reg_in_range),
    .rdata    (reg_rdata)
  );

  always_comb begin
    io_rdata = IDLE_BYTE;
    if (io_rd && access_open) begin
      if (hit_index)      io_rdata = index_q;
      else if (hit_data)  io_rdata = reg_rdata;
      else if (hit_idout) io_rdata = id_byte(chip_id_q);
    end
  end

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
  import cfgport_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h8A
) (
  input logic            clk,
  input logic            rst_n,
  input logic            io_rd,
  input logic            io_wr,
  input logic [7:0]      io_wdata,
  input logic [7:0]      io_rdata,
  input logic            hit_idin,
  input logic            hit_index,
  input logic            hit_data,
  input logic            hit_idout,
  input logic            access_open,
  input logic            seq_active,
  input logic            single_q,
  input logic            base_q,
  input logic [ID_W-1:0] chip_id_q,
  input logic [7:0]      index_q,
  input logic            reg_in_range
);

  // R1
  port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_idin, hit_index, hit_data, hit_idout}));

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'hFF);

  // R3
  single_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    single_q |-> access_open);

  // R4
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_q && io_wr && hit_idin && io_wdata == id_byte(chip_id_q)) |=> seq_active);

  // R4
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_q && io_wr && hit_idin && io_wdata != id_byte(chip_id_q)) |=> !seq_active);

  // R5
  idout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit_idout && access_open) |-> io_rdata == id_byte(chip_id_q));

  // R6
  closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !access_open && (hit_index || hit_data)) |-> io_rdata == 8'hFF);

  // R6
  closed_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !access_open) |=> $stable(index_q));

  // R9
  rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && access_open && hit_data && index_q == 8'h87) |-> io_rdata == REV_ID);

  // R10
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && access_open && hit_data && !reg_in_range) |-> io_rdata == 8'hFF);

  // R12
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(base_q) && $stable(single_q) && $stable(chip_id_q)));

endmodule

bind cfgport_top cfgport_chk #(.REV_ID(REV_ID)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_rd        (io_rd),
  .io_wr        (io_wr),
  .io_wdata     (io_wdata),
  .io_rdata     (io_rdata),
  .hit_idin     (hit_idin),
  .hit_index    (hit_index),
  .hit_data     (hit_data),
  .hit_idout    (hit_idout),
  .access_open  (access_open),
  .seq_active   (seq_active),
  .single_q     (single_q),
  .base_q       (base_q),
  .chip_id_q    (chip_id_q),
  .index_q      (index_q),
  .reg_in_range (reg_in_range)
);

// File: tb/cfgport_top_tb_top.sv
`timescale 1ns/1ps
module cfgport_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_base = 1'b1, strap_single = 1'b1, strap_id1 = 1'b1, strap_id0 = 1'b0;
  logic [9:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mdl [16];

  always #5 clk = ~clk;

  cfgport_top dut_i (
    .clk(clk), .rst_n(rst_n), .strap_base(strap_base), .strap_single(strap_single),
    .strap_id1(strap_id1), .strap_id0(strap_id0), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  function automatic logic is_ro(input int i);
    return (i == 0) || (i == 2) || (i == 4) || (i == 7);
  endfunction

  function automatic logic [7:0] dflt(input int i);
    if (i <= 1) return 8'h8F;
    if (i <= 5) return 8'hFF;
    if (i == 6) return 8'h80;
    if (i == 7) return 8'h8A;
    return 8'h00;
  endfunction

  task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic b, input logic s, input logic [1:0] id);
    strap_base = b; strap_single = s; {strap_id1, strap_id0} = id;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) mdl[i] = dflt(i);
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    io_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [9:0] pa;

    // Single-chip, high base, id 2
    do_reset(1'b1, 1'b1, 2'd2);
    @(negedge clk); #2;
    cmp("R11 idle bus", io_rdata, 8'hFF);
    rd(10'h1B4, v); cmp("R7 index reset", v, 8'h00);
    rd(10'h1BC, v); cmp("R5 id-out single", v, 8'h02);
    rd(10'h1B0, v); cmp("R11 id-in read", v, 8'hFF);
    rd(10'h134, v); cmp("R1 other base index", v, 8'hFF);
    rd(10'h000, v); cmp("R11 no hit", v, 8'hFF);
    rd(10'h3B4, v); cmp("R1 bit9 index", v, 8'hFF);
    // R8 R9 R10 full index sweep of defaults
    for (int i = 0; i < 256; i++) begin
      wr(10'h1B4, 8'(i));
      rd(10'h1B4, v); cmp("R7 index readback", v, 8'(i));
      rd(10'h1B8, v);
      if (i >= 8'h80 && i <= 8'h8F) cmp("R8 default", v, dflt(i - 8'h80));
      else cmp("R10 out of range read", v, 8'hFF);
    end
    // Write every in-range index its own pattern
    for (int i = 0; i < 16; i++) begin
      wr(10'h1B4, 8'(8'h80 + i));
      wr(10'h1B8, 8'(i * 17) ^ 8'h5A);
      if (!is_ro(i)) mdl[i] = 8'(i * 17) ^ 8'h5A;
    end
    // Then hit every out-of-range index with a data write
    for (int i = 0; i < 256; i++) begin
      if (i < 8'h80 || i > 8'h8F) begin
        wr(10'h1B4, 8'(i));
        wr(10'h1B8, 8'hC3);
      end
    end
    for (int i = 0; i < 16; i++) begin
      wr(10'h1B4, 8'(8'h80 + i));
      rd(10'h1B8, v);
      if (is_ro(i)) cmp("R9 read-only kept", v, dflt(i));
      else cmp("R10 rw survives out-of-range", v, mdl[i]);
    end

    // Multi-chip sweep over base and chip ID
    for (int b = 0; b < 2; b++) begin
      for (int id = 0; id < 4; id++) begin
        do_reset(b[0], 1'b0, 2'(id));
        pa = b[0] ? 10'h1B0 : 10'h130;
        rd(pa + 10'd4, v); cmp("R6 closed index read", v, 8'hFF);
        rd(pa + 10'd12, v); cmp("R5 closed id-out", v, 8'hFF);
        wr(pa + 10'd4, 8'h81);
        for (int c = 0; c < 4; c++) begin
          wr(pa, 8'(c));
          rd(pa + 10'd12, v);
          cmp("R4 id compare", v, (c == id) ? 8'(id) : 8'hFF);
        end
        wr(pa, 8'(id));
        rd(pa + 10'd12, v); cmp("R5 id-out open", v, 8'(id));
        rd(pa + 10'd4, v); cmp("R6 locked index write ignored", v, 8'h00);
        wr(pa + 10'd4, 8'h81);
        wr(pa + 10'd8, 8'h3C);
        rd(pa + 10'd8, v); cmp("R4 open data rw", v, 8'h3C);
        wr(pa, 8'(id ^ 1));
        rd(pa + 10'd8, v); cmp("R6 closed data read", v, 8'hFF);
        wr(pa + 10'd8, 8'h99);
        wr(pa, 8'(id));
        rd(pa + 10'd8, v); cmp("R6 locked data write ignored", v, 8'h3C);
        // R1: the other base does not respond
        wr(pa ^ 10'h080, 8'(id ^ 2));
        rd(pa ^ 10'h080 + 10'd12, v); cmp("R1 other base id-out", v, 8'hFF);
        rd(pa + 10'd12, v); cmp("R1 other base id-in ignored", v, 8'(id));
        // R2 alias sweep on bits 9:8
        for (int h = 0; h < 4; h++) begin
          wr(pa, 8'(id ^ 1));
          wr({2'(h), pa[7:0]}, 8'(id));
          rd(pa + 10'd12, v);
          cmp("R2 id-in alias", v, (h < 2) ? 8'(id) : 8'hFF);
        end
      end
    end

    // R12 strap changes after reset ignored
    do_reset(1'b1, 1'b1, 2'd2);
    strap_base = 1'b0; strap_single = 1'b0; {strap_id1, strap_id0} = 2'd3;
    repeat (2) @(negedge clk);
    rd(10'h1BC, v); cmp("R12 id kept", v, 8'h02);
    rd(10'h1B4, v); cmp("R12 mode kept", v, 8'h00);
    rd(10'h134, v); cmp("R12 base kept", v, 8'hFF);
    wr(10'h1B4, 8'h87);
    rd(10'h1B8, v); cmp("R9 revision", v, 8'h8A);
    wr(10'h1B8, 8'h00);
    rd(10'h1B8, v); cmp("R9 revision write dropped", v, 8'h8A);
    wr(10'h1B4, 8'h86);
    rd(10'h1B8, v); cmp("R3 single access", v, 8'h80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule